// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block keeps the pending-interrupt state for a small peripheral that contains two timers and a serial shift unit. Seven flag bits record events, and seven enable bits say which of those events are allowed to reach the processor. Single-cycle event pulses from the timers and from the shift logic set flag bits. A flag bit is cleared in one of two ways: the host writes a one to it, or the timer logic raises a side-effect clear strobe, for example when the host touches a counter register.

The host reaches both registers through a byte-wide register port with an index-selected read path. Bit 7 of a flag read is a live summary: it is 1 whenever any enabled flag is pending. Bit 7 of an enable read is always 1. On an enable write, bit 7 chooses whether the ones in bits 6:0 set enable bits or clear them. One level-sensitive interrupt output serves the processor, and only the shift-unit and Timer 1 sources can drive it.

Top module: `irqpair_top`

## Requirements
- R1: After reset, and after any later reset, every flag and every enable is zero: a flag read returns 0x00, an enable read returns 0x80, and `irq_out` is low.
- R2: A one on `evt_set[i]` at a clock edge sets flag bit i. The bit then stays set until something clears it. The shift unit uses bit 2 (0x04), Timer 2 uses bit 5 (0x20) and Timer 1 uses bit 6 (0x40).
- R3: A write to the flag index (13) clears every flag bit whose `bus_wdata` bit is 1, within bits 6:0. Flag bits written with 0 keep their value.
- R4: A one on `evt_clr[i]` at a clock edge clears flag bit i.
- R5: If a set pulse and a clear (a host write or a strobe) reach the same flag bit at the same edge, the flag ends up set.
- R6: A write to the enable index (14) with `bus_wdata[7]`=1 sets every enable bit whose data bit 6:0 is 1. The other enable bits do not change.
- R7: A write to the enable index with `bus_wdata[7]`=0 clears every enable bit whose data bit 6:0 is 1. The other enable bits do not change.
- R8: A read at the enable index returns the enables in bits 6:0 with bit 7 always 1.
- R9: A read at the flag index returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag bit is set and its enable bit is also set, and this holds for every one of the seven positions.
- R10: `irq_out` is high exactly when the shift bit (2) or the Timer 1 bit (6) is both pending and enabled. Pending and enabled bits at any other position, Timer 2 included, leave `irq_out` low.
- R11: A write to any index other than 13 or 14 leaves flags, enables and `irq_out` unchanged. A read at such an index returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register index used for both reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, a combinational function of the stored state |
| evt_set | input | 7 | Event pulses that set flags, one bit per source |
| evt_clr | input | 7 | Side-effect clear strobes from the timer logic, one bit per flag |
| irq_out | output | 1 | Level interrupt request to the processor |

## Verification
The assertions assume that `bus_wr`, `bus_addr`, `bus_wdata`, `evt_set` and `evt_clr` hold known, settled values at every rising edge. They also assume that each event or strobe is meant to act on exactly the edge at which it is high. The stimulus changes these inputs only on the falling edge or just after the rising edge, and it returns them to zero after each active cycle. The read path is probed only after the inputs have settled again, so every sampled read shows the state from the previous edge. Simultaneous set and clear is applied on purpose, through both the host-write path and the strobe path, so that the set-wins rule is checked under each clear source.

// File: rtl/irqpair_pkg.sv
package irqpair_pkg;

    localparam int SRC_W  = 7;
    localparam int BYTE_W = 8;

    localparam int SHIFT_POS = 2;
    localparam int TMR2_POS  = 5;
    localparam int TMR1_POS  = 6;

    typedef logic [SRC_W-1:0]  src_vec_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam src_vec_t IRQ_SOURCES =
        src_vec_t'((1 << SHIFT_POS) | (1 << TMR1_POS));

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_FLAG   = 2'd1,
        SEL_ENABLE = 2'd2
    } reg_sel_t;

    typedef struct packed {
        src_vec_t flag_clr;
        src_vec_t en_set;
        src_vec_t en_clr;
    } wr_ctrl_t;

    function automatic src_vec_t next_flags(src_vec_t cur, src_vec_t set_v, src_vec_t clr_v);
        return (cur & ~clr_v) | set_v;
    endfunction

    function automatic src_vec_t next_enables(src_vec_t cur, src_vec_t set_v, src_vec_t clr_v);
        return (cur | set_v) & ~clr_v;
    endfunction

    function automatic byte_t read_word(logic top_bit, src_vec_t body);
        return {top_bit, body};
    endfunction

endpackage

// File: rtl/irqpair_decode.sv
module irqpair_decode
    import irqpair_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int FLAG_INDEX   = 13,
    parameter int ENABLE_INDEX = 14
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  byte_t             bus_wdata,
    output reg_sel_t          sel,
    output wr_ctrl_t          wctl
);

    localparam logic [ADDR_W-1:0] FLAG_A   = ADDR_W'(FLAG_INDEX);
    localparam logic [ADDR_W-1:0] ENABLE_A = ADDR_W'(ENABLE_INDEX);

    src_vec_t payload;
    logic     mode_set;

    assign payload  = bus_wdata[SRC_W-1:0];
    assign mode_set = bus_wdata[BYTE_W-1];

    always_comb begin
        if (bus_addr == FLAG_A) begin
            sel = SEL_FLAG;
        end else if (bus_addr == ENABLE_A) begin
            sel = SEL_ENABLE;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        wctl = '0;
        if (bus_wr) begin
            unique case (sel)
                SEL_FLAG:   wctl.flag_clr = payload;
                SEL_ENABLE: begin
                    if (mode_set) wctl.en_set = payload;
                    else          wctl.en_clr = payload;
                end
                default: wctl = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqpair_flag_bank.sv
module irqpair_flag_bank
    import irqpair_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt_set,
    input  src_vec_t strobe_clr,
    input  src_vec_t host_clr,
    output src_vec_t flags
);

    src_vec_t clr_all;
    assign clr_all = strobe_clr | host_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= next_flags(flags, evt_set, clr_all);
        end
    end

    // R2 and R5: a set pulse always leaves its flag set, whatever clear arrives with it
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (evt_set != '0) |=> ((flags & $past(evt_set)) == $past(evt_set)));

    // R3: host write clears the written ones that have no set pulse with them
    a_r3_host_clear: assert property (@(posedge clk) disable iff (rst)
        ((host_clr & ~evt_set) != '0) |=> ((flags & $past(host_clr & ~evt_set)) == '0));

    // R4: strobe clears its flag
    a_r4_strobe_clear: assert property (@(posedge clk) disable iff (rst)
        ((strobe_clr & ~evt_set) != '0) |=> ((flags & $past(strobe_clr & ~evt_set)) == '0));

    // R11: with no set and no clear the flags hold
    a_r11_flags_hold: assert property (@(posedge clk) disable iff (rst)
        ((evt_set | clr_all) == '0) |=> $stable(flags));

endmodule

// File: rtl/irqpair_enable_bank.sv
module irqpair_enable_bank
    import irqpair_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t en_set,
    input  src_vec_t en_clr,
    output src_vec_t enables
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enables <= '0;
        end else begin
            enables <= next_enables(enables, en_set, en_clr);
        end
    end

    // R6: set-mode write turns the selected enables on
    a_r6_enable_set: assert property (@(posedge clk) disable iff (rst)
        (en_set != '0) |=> ((enables & $past(en_set)) == $past(en_set)));

    // R7: clear-mode write turns the selected enables off
    a_r7_enable_clear: assert property (@(posedge clk) disable iff (rst)
        (en_clr != '0) |=> ((enables & $past(en_clr)) == '0));

    // R6 and R7: untouched enable bits hold
    a_r7_enable_hold: assert property (@(posedge clk) disable iff (rst)
        ((en_set | en_clr) == '0) |=> $stable(enables));

endmodule

// File: rtl/irqpair_readback.sv
module irqpair_readback
    import irqpair_pkg::*;
#(
    parameter src_vec_t LINE_MASK = IRQ_SOURCES
) (
    input  logic     clk,
    input  logic     rst,
    input  reg_sel_t sel,
    input  src_vec_t flags,
    input  src_vec_t enables,
    output byte_t    rdata,
    output logic     irq
);

    src_vec_t live;
    logic     summary;

    assign live    = flags & enables;
    assign summary = |live;
    assign irq     = |(live & LINE_MASK);

    always_comb begin
        unique case (sel)
            SEL_FLAG:   rdata = read_word(summary, flags);
            SEL_ENABLE: rdata = read_word(1'b1, enables);
            default:    rdata = '0;
        endcase
    end

    // R8: enable read always shows bit 7
    a_r8_enable_top_bit: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_ENABLE) |-> (rdata[BYTE_W-1] && rdata[SRC_W-1:0] == enables));

    // R9: flag read bit 7 tracks any enabled pending flag
    a_r9_flag_summary: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_FLAG) |-> (rdata[BYTE_W-1] == ((flags & enables) != '0)));

    // R10: the line only rises for a pending, enabled line source
    a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flags & enables & LINE_MASK) != '0));

    // R10: Timer 2 on its own never drives the line
    a_r10_tmr2_silent: assert property (@(posedge clk) disable iff (rst)
        ((flags & enables) == src_vec_t'(1 << TMR2_POS)) |-> !irq);

endmodule

// File: rtl/irqpair_top.sv
module irqpair_top
    import irqpair_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int FLAG_INDEX   = 13,
    parameter int ENABLE_INDEX = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [6:0]        evt_set,
    input  logic [6:0]        evt_clr,
    output logic              irq_out
);

    reg_sel_t sel;
    wr_ctrl_t wctl;
    src_vec_t flags;
    src_vec_t enables;

    irqpair_decode #(
        .ADDR_W       (ADDR_W),
        .FLAG_INDEX   (FLAG_INDEX),
        .ENABLE_INDEX (ENABLE_INDEX)
    ) u_decode (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sel       (sel),
        .wctl      (wctl)
    );

    irqpair_flag_bank u_flags (
        .clk        (clk),
        .rst        (rst),
        .evt_set    (evt_set),
        .strobe_clr (evt_clr),
        .host_clr   (wctl.flag_clr),
        .flags      (flags)
    );

    irqpair_enable_bank u_enables (
        .clk     (clk),
        .rst     (rst),
        .en_set  (wctl.en_set),
        .en_clr  (wctl.en_clr),
        .enables (enables)
    );

    irqpair_readback #(
        .LINE_MASK (IRQ_SOURCES)
    ) u_read (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .flags   (flags),
        .enables (enables),
        .rdata   (bus_rdata),
        .irq     (irq_out)
    );

    // R11: a write outside the two indices changes no state
    a_r11_foreign_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_NONE && evt_set == '0 && evt_clr == '0)
            |=> ($stable(flags) && $stable(enables)));

endmodule

// File: tb/sim_irqpair_top.sv
module sim_irqpair_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 16;

    // {wr, addr, wdata, evt_set, evt_clr, exp_flag_read, exp_enable_read, exp_irq}
    localparam logic [43:0] VEC [NVEC] = '{
        {1'b0, 4'd0,  8'h00, 7'h04, 7'h00, 8'h04, 8'h80, 1'b0}, // R2 shift event
        {1'b1, 4'd14, 8'h84, 7'h00, 7'h00, 8'h84, 8'h84, 1'b1}, // R6 enable shift
        {1'b0, 4'd0,  8'h00, 7'h20, 7'h00, 8'hA4, 8'h84, 1'b1}, // R2 timer2 event
        {1'b1, 4'd13, 8'h04, 7'h00, 7'h00, 8'h20, 8'h84, 1'b0}, // R3 clear shift
        {1'b1, 4'd14, 8'hA0, 7'h00, 7'h00, 8'hA0, 8'hA4, 1'b0}, // R10 timer2 no line
        {1'b0, 4'd0,  8'h00, 7'h00, 7'h20, 8'h00, 8'hA4, 1'b0}, // R4 strobe clear
        {1'b0, 4'd0,  8'h00, 7'h40, 7'h40, 8'h40, 8'hA4, 1'b0}, // R5 set vs strobe
        {1'b1, 4'd14, 8'hC0, 7'h00, 7'h00, 8'hC0, 8'hE4, 1'b1}, // R6 enable timer1
        {1'b1, 4'd13, 8'h40, 7'h40, 7'h00, 8'hC0, 8'hE4, 1'b1}, // R5 set vs host
        {1'b1, 4'd14, 8'h40, 7'h00, 7'h00, 8'h40, 8'hA4, 1'b0}, // R7 disable timer1
        {1'b1, 4'd5,  8'hFF, 7'h00, 7'h00, 8'h40, 8'hA4, 1'b0}, // R11 foreign write
        {1'b1, 4'd13, 8'h00, 7'h00, 7'h00, 8'h40, 8'hA4, 1'b0}, // R3 zero write
        {1'b0, 4'd0,  8'h00, 7'h01, 7'h00, 8'h41, 8'hA4, 1'b0}, // R2 bit0 event
        {1'b1, 4'd14, 8'h81, 7'h00, 7'h00, 8'hC1, 8'hA5, 1'b0}, // R10 bit0 no line
        {1'b1, 4'd13, 8'h7F, 7'h00, 7'h00, 8'h00, 8'hA5, 1'b0}, // R3 clear all
        {1'b1, 4'd14, 8'h7F, 7'h00, 7'h00, 8'h00, 8'h80, 1'b0}  // R7 clear all
    };

    localparam string TAG [NVEC] = '{
        "R2", "R6", "R2", "R3", "R10", "R4", "R5", "R6",
        "R5", "R7", "R11", "R3", "R2", "R10", "R3", "R7"
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [6:0] evt_set = 7'h00;
    logic [6:0] evt_clr = 7'h00;
    logic       irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqpair_top u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_set   (evt_set),
        .evt_clr   (evt_clr),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic cycle(input logic wr, input logic [3:0] a, input logic [7:0] d,
                         input logic [6:0] s, input logic [6:0] c);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_set = s; evt_clr = c;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_wdata = 8'h00; evt_set = 7'h00; evt_clr = 7'h00;
    endtask

    task automatic observe(input string tag, input logic [7:0] ef, input logic [7:0] ee,
                           input logic ei);
        bus_addr = 4'd13; #1;
        check(tag, bus_rdata, ef);
        bus_addr = 4'd14; #1;
        check(tag, bus_rdata, ee);
        check(tag, {7'h00, irq_out}, {7'h00, ei});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1 reset state
        observe("R1", 8'h00, 8'h80, 1'b0);
        bus_addr = 4'd3; #1;
        check("R11", bus_rdata, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            cycle(VEC[i][43], VEC[i][42:39], VEC[i][38:31], VEC[i][30:24], VEC[i][23:17]);
            observe(TAG[i], VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
        end

        // R9 summary bit for every position, one at a time
        for (int b = 0; b < 7; b++) begin
            cycle(1'b0, 4'd0, 8'h00, 7'(1 << b), 7'h00);
            bus_addr = 4'd13; #1;
            check("R9", bus_rdata, {1'b0, 7'(1 << b)});
            cycle(1'b1, 4'd14, 8'h80 | 8'(1 << b), 7'h00, 7'h00);
            bus_addr = 4'd13; #1;
            check("R9", bus_rdata, {1'b1, 7'(1 << b)});
            cycle(1'b1, 4'd13, 8'(1 << b), 7'h00, 7'h00);
            cycle(1'b1, 4'd14, 8'(1 << b), 7'h00, 7'h00);
            observe("R9", 8'h00, 8'h80, 1'b0);
        end

        // R10 all pending and enabled, then R1 reset in the middle of a run
        cycle(1'b0, 4'd0, 8'h00, 7'h7F, 7'h00);
        cycle(1'b1, 4'd14, 8'hFF, 7'h00, 7'h00);
        observe("R10", 8'hFF, 8'hFF, 1'b1);
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        observe("R1", 8'h00, 8'h80, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule